// File: doc/BRIEF.md
# Scan Self-Test Sequencer

This block runs a test-per-scan self-test over a set of scan chains. A start request latches a load length and a pattern total. The block then loops through two phases. In the load phase the chains are in scan mode: a new stimulus shifts in while the previous response shifts out. In the capture phase the chains are in system mode for a programmable number of clocks, so the loaded stimulus is applied to the logic and its response is captured.

The stimulus generator, the signature compactor and the logic under test sit outside the block. The sequencer only drives their enables. It keeps the compactor off while the chains are first filled, because they hold no response yet. After the last capture, one more load-length unload pushes the final response into the compactor without counting a new pattern. Compaction then stops, so the signature stays frozen for readout, and a done flag is held until the next start.

The states are IDLE, SHIFT, CAPTURE, FINAL_UNLOAD and DONE. The transitions are:
- IDLE to SHIFT on an accepted start.
- SHIFT to CAPTURE on the last clock of a load.
- CAPTURE to SHIFT on the last capture clock when patterns remain.
- CAPTURE to FINAL_UNLOAD on the last capture clock of the last pattern.
- FINAL_UNLOAD to DONE on its last clock.
- DONE to SHIFT on an accepted start.

The load length set by software must be at least the length of the longest chain.

Top module: `scanbist_ctrl`

## Requirements
- R1: After reset, `scan_en_o`, `gen_en_o`, `cmp_en_o`, `cap_en_o` and `done_o` are all low, and the block waits in IDLE. All outputs are active high.
- R2: A start seen at a rising edge in IDLE begins a load on the next cycle. Every load holds `scan_en_o` and `gen_en_o` high for exactly L cycles, where L is `shift_len_i` latched at start, and 0 is taken as 1.
- R3: `cmp_en_o` is low during the first load of a test. It is high during every later load and during the final unload.
- R4: After each load, `cap_en_o` is high for k consecutive cycles, with `scan_en_o`, `gen_en_o` and `cmp_en_o` low. k is `cap_k_i` sampled on the last load cycle, 0 is taken as 1, and k may differ from one load to the next.
- R5: P load-and-capture rounds are applied, where P is `pat_total_i` latched at start and 0 is taken as 1. They are followed by L unload cycles with `scan_en_o` and `cmp_en_o` high and `gen_en_o` low.
- R6: After the unload, `done_o` is high and every other output is low. This holds for as long as start stays low.
- R7: While a test runs, `start_i` has no effect, and changes on `shift_len_i` or `pat_total_i` do not alter the running sequence.
- R8: A start seen while in DONE clears `done_o` and begins a new test with freshly latched settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled at rising edge |
| shift_len_i | input | LEN_W | Scan clocks per load |
| pat_total_i | input | PAT_W | Number of patterns in a test |
| cap_k_i | input | CAP_W | Capture clocks after the current load |
| scan_en_o | output | 1 | Chains in scan (shift) mode |
| gen_en_o | output | 1 | Stimulus generator advance |
| cmp_en_o | output | 1 | Signature compaction enable |
| cap_en_o | output | 1 | System-mode capture clock enable |
| done_o | output | 1 | Test complete, signature valid |

## Verification
The outputs are compared on every cycle against a trace that a bench function builds from L, P and a list of per-load k values.

Random runs mix long and short loads with varied capture counts per load. This separates off-by-one faults in the load counter from faults in the capture counter, and shows whether k is picked up per load rather than once per test.

Directed runs cover the corners:
- L=1 with P=1 and k=0, where the zero-means-one rules and single-cycle phases meet.
- A single pattern, which has no compacted load at all.
- A run in which start and the settings are changed mid-test.
- A back-to-back restart from DONE, which tells a held done flag apart from a pulsed one.

// File: rtl/scanbist_pkg.sv
package scanbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_UNLOAD,
        ST_DONE
    } bist_state_t;

    typedef struct packed {
        logic scan;
        logic gen;
        logic cmp;
        logic cap;
        logic done;
    } bist_ctl_t;

    localparam bist_ctl_t CTL_OFF = '{scan: 1'b0, gen: 1'b0, cmp: 1'b0, cap: 1'b0, done: 1'b0};

endpackage

// File: rtl/sb_step_counter.sv
module sb_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    assign last_o = (cnt_q == limit_i - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (last_o) cnt_q <= '0;
            else        cnt_q <= cnt_q + ONE;
        end
    end

    // R2
    step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i)
        else $error("step counter beyond its limit");

    // R4
    step_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_q))
        else $error("step counter moved while disabled");

endmodule

// File: rtl/sb_pattern_counter.sv
module sb_pattern_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] total_i,
    output logic         first_o,
    output logic         last_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    assign first_o = (cnt_q == '0);
    assign last_o  = (cnt_q == total_i - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            if (last_o) cnt_q <= '0;
            else        cnt_q <= cnt_q + ONE;
        end
    end

    // R5
    pat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < total_i)
        else $error("pattern count beyond total");

    // R5
    pat_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !last_o && !clr_i) |=> (cnt_q == $past(cnt_q) + ONE))
        else $error("pattern count did not advance by one");

endmodule

// File: rtl/scanbist_ctrl.sv
module scanbist_ctrl
    import scanbist_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int PAT_W = 16,
    parameter int CAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] shift_len_i,
    input  logic [PAT_W-1:0] pat_total_i,
    input  logic [CAP_W-1:0] cap_k_i,
    output logic             scan_en_o,
    output logic             gen_en_o,
    output logic             cmp_en_o,
    output logic             cap_en_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [PAT_W-1:0] PAT_ONE = PAT_W'(1);
    localparam logic [CAP_W-1:0] CAP_ONE = CAP_W'(1);

    bist_state_t state_q, state_d;
    bist_ctl_t   ctl;

    logic [LEN_W-1:0] len_q;
    logic [PAT_W-1:0] tot_q;
    logic [CAP_W-1:0] k_q;

    logic accept;
    logic sh_en, sh_last;
    logic cap_cnt_en, cap_last;
    logic pat_inc, pat_first, pat_last;
    logic load_end;

    assign accept     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign sh_en      = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
    assign cap_cnt_en = (state_q == ST_CAPTURE);
    assign pat_inc    = cap_cnt_en && cap_last;
    assign load_end   = (state_q == ST_SHIFT) && sh_last;

    // settings latched on an accepted start; capture count per load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_ONE;
            tot_q <= PAT_ONE;
            k_q   <= CAP_ONE;
        end else begin
            if (accept) begin
                len_q <= (shift_len_i == '0) ? LEN_ONE : shift_len_i;
                tot_q <= (pat_total_i == '0) ? PAT_ONE : pat_total_i;
            end
            if (load_end) begin
                k_q <= (cap_k_i == '0) ? CAP_ONE : cap_k_i;
            end
        end
    end

    sb_step_counter #(.W(LEN_W)) u_shift_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .en_i    (sh_en),
        .limit_i (len_q),
        .last_o  (sh_last)
    );

    sb_step_counter #(.W(CAP_W)) u_cap_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .en_i    (cap_cnt_en),
        .limit_i (k_q),
        .last_o  (cap_last)
    );

    sb_pattern_counter #(.W(PAT_W)) u_pat_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .inc_i   (pat_inc),
        .total_i (tot_q),
        .first_o (pat_first),
        .last_o  (pat_last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)   state_d = ST_SHIFT;
            ST_SHIFT:   if (sh_last)  state_d = ST_CAPTURE;
            ST_CAPTURE: if (cap_last) state_d = pat_last ? ST_UNLOAD : ST_SHIFT;
            ST_UNLOAD:  if (sh_last)  state_d = ST_DONE;
            ST_DONE:    if (accept)   state_d = ST_SHIFT;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        ctl = CTL_OFF;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHIFT: begin
                ctl.scan = 1'b1;
                ctl.gen  = 1'b1;
                ctl.cmp  = !pat_first;
            end
            ST_CAPTURE: ctl.cap = 1'b1;
            ST_UNLOAD: begin
                ctl.scan = 1'b1;
                ctl.cmp  = 1'b1;
            end
            ST_DONE: ctl.done = 1'b1;
            default: ;
        endcase
    end

    assign scan_en_o = ctl.scan;
    assign gen_en_o  = ctl.gen;
    assign cmp_en_o  = ctl.cmp;
    assign cap_en_o  = ctl.cap;
    assign done_o    = ctl.done;

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o)
        else $error("done dropped without start");

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sh_en) |=> ($stable(len_q) && $stable(tot_q)))
        else $error("settings relatched during a test");

    // R4
    cap_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_en_o) |-> $past(scan_en_o))
        else $error("capture without preceding load");

    // R5
    shift_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_en_o) |-> scan_en_o)
        else $error("capture not followed by a scan phase");

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (scan_en_o && !done_o))
        else $error("start in done did not restart");

endmodule

// File: tb/sim_scanbist_ctrl.sv
module sim_scanbist_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  shift_len_i = '0;
    logic [15:0] pat_total_i = '0;
    logic [3:0]  cap_k_i = '0;
    logic scan_en_o, gen_en_o, cmp_en_o, cap_en_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanbist_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .shift_len_i(shift_len_i), .pat_total_i(pat_total_i), .cap_k_i(cap_k_i),
        .scan_en_o(scan_en_o), .gen_en_o(gen_en_o), .cmp_en_o(cmp_en_o),
        .cap_en_o(cap_en_o), .done_o(done_o)
    );

    // phase codes: 0 idle, 1 load, 2 capture, 3 unload, 4 done
    // expected {scan, gen, cmp, cap, done}
    function automatic logic [4:0] exp_vec(int phase, int pat);
        case (phase)
            1:       return {1'b1, 1'b1, (pat != 0), 1'b0, 1'b0};
            2:       return 5'b00010;
            3:       return 5'b10100;
            4:       return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(int phase, int pat, string tag);
        logic [4:0] act, exp;
        act = {scan_en_o, gen_en_o, cmp_en_o, cap_en_o, done_o};
        exp = exp_vec(phase, pat);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s phase %0d pattern %0d actual %b expected %b", tag, phase, pat, act, exp);
        end
    endtask

    // runs one test; poke disturbs start and settings mid-test (R7)
    task automatic run(int len, int pats, int ks[8], bit poke, string tag0);
        int le = eff(len);
        int pe = eff(pats);
        shift_len_i = 8'(len);
        pat_total_i = 16'(pats);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int p = 0; p < pe; p++) begin
            for (int s = 0; s < le; s++) begin
                check(1, p, (p == 0 && s == 0 && tag0 != "") ? tag0 : (p == 0 ? "R3" : "R2"));
                if (s == 0) cap_k_i = 4'(ks[p % 8]);
                start_i = poke && (p == 0) && (s == 0);
                if (poke && p == 0 && s == 0) begin
                    shift_len_i = 8'(le + 3);
                    pat_total_i = 16'(pe + 2);
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            for (int c = 0; c < eff(ks[p % 8]); c++) begin
                check(2, p, poke ? "R7" : "R4");
                start_i = poke;
                @(negedge clk);
            end
            start_i = 1'b0;
        end
        for (int s = 0; s < le; s++) begin
            check(3, pe, poke ? "R7" : "R5");
            @(negedge clk);
        end
        for (int d = 0; d < 3; d++) begin
            check(4, 0, "R6");
            @(negedge clk);
        end
    endtask

    initial begin
        int ks[8];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(0, 0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(0, 0, "R1");
        // start held low: stays idle (R1)
        repeat (2) @(negedge clk);
        check(0, 0, "R1");

        // directed: smallest case, zeros mean one (R2 R4 R5)
        ks = '{0, 0, 0, 0, 0, 0, 0, 0};
        run(0, 0, ks, 1'b0, "R2");

        // directed: single pattern, varied k
        ks = '{3, 1, 1, 1, 1, 1, 1, 1};
        run(5, 1, ks, 1'b0, "R8");

        // directed: k changes per load (R4)
        ks = '{1, 4, 2, 7, 1, 1, 1, 1};
        run(3, 4, ks, 1'b0, "R8");

        // directed: start and settings disturbed while running (R7)
        ks = '{2, 1, 3, 1, 1, 1, 1, 1};
        run(4, 3, ks, 1'b1, "R8");

        // done held over a long idle stretch (R6)
        repeat (20) @(negedge clk);
        check(4, 0, "R6");

        // random runs
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 8; i++) ks[i] = int'($urandom_range(0, 6));
            run(int'($urandom_range(1, 14)), int'($urandom_range(1, 6)), ks, r[0], "R8");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule